// File: doc/BRIEF.md
# Quarter-Rate Complex Downconverter with Decimation by Two

This block takes a stream of signed real samples and turns it into a stream of complex baseband pairs. The complex carrier runs at exactly one quarter of the input sample rate, so each carrier component only ever takes the values +1, 0 and -1. Mixing therefore needs no multipliers. Each sample is passed through, negated, or dropped. On each channel every second input sample meets a zero carrier value, and those samples are the ones thrown away. That drop is the decimation by two, so I and Q each leave at half the input rate. For example, a 100 MS/s input gives 50 MS/s on each output channel.

Samples enter with a valid strobe and may arrive with gaps. A two-bit phase position moves forward only on accepted samples, so gaps do not change which samples are paired. Each output pair appears with its own one-cycle valid strobe. The outputs are one bit wider than the input, so negating the most negative input value stays exact.

Top module: `iq_qrate_ddc`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and out_i and out_q are 0. The next accepted sample after any reset is treated as phase 0.
- R2: Accepted samples are numbered from 0 since reset, and the phase is that number modulo 4. The in-phase carrier over phases 0, 1, 2, 3 is +1, 0, -1, 0. So out_i carries +x for a phase-0 sample and -x for a phase-2 sample, sign-extended to IN_W+1 bits.
- R3: The quadrature carrier over phases 0, 1, 2, 3 is 0, -1, 0, +1. So out_q carries -x for a phase-1 sample and +x for a phase-3 sample.
- R4: out_valid is high for exactly one cycle, in the cycle after each accepted phase-1 or phase-3 sample, and is low in every other cycle. This gives one pair per two accepted samples.
- R5: A cycle with in_valid low neither advances the phase nor produces output. Pairing depends only on the count of accepted samples.
- R6: Negating the most negative input value, -2^(IN_W-1), gives +2^(IN_W-1) with no wrap.
- R7: When out_valid is low, out_i and out_q keep the values of the last pair.
- R8: Each pair joins the I value of the preceding even-phase sample with the Q value of the odd-phase sample that closes the pair. Phase 0 goes with phase 1, and phase 2 goes with phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | IN_W | Signed real input sample |
| out_valid | output | 1 | One-cycle strobe marking a new I/Q pair |
| out_i | output | IN_W+1 | Signed in-phase output |
| out_q | output | IN_W+1 | Signed quadrature output |

## Verification
The hardest case to reach from the ports is full coverage of sample value against phase. Every input value, including the most negative one, must be seen at each of the four carrier phases, and idle gaps must fall between samples of the same pair. The bench uses a 4-bit input so the value set is small. It sends 64 samples whose value is offset by their phase, so every value meets every phase. It drops in_valid on a fixed pattern so that gaps land inside pairs as well as between them. A reset in the middle of a pair then checks that the half-built pair is abandoned.

// File: rtl/iq_qrate_pkg.sv
package iq_qrate_pkg;
   // Position within the four-sample carrier cycle
   typedef enum logic [1:0] {
      PH_IPOS = 2'd0,
      PH_QNEG = 2'd1,
      PH_INEG = 2'd2,
      PH_QPOS = 2'd3
   } qphase_e;

   // Channel selector for the lane generate loop
   localparam int LANE_I = 0;
   localparam int LANE_Q = 1;
   localparam int NUM_LANES = 2;

   function automatic logic [1:0] lane_pos_phase(input int lane);
      return (lane == LANE_I) ? 2'(PH_IPOS) : 2'(PH_QPOS);
   endfunction

   function automatic logic [1:0] lane_neg_phase(input int lane);
      return (lane == LANE_I) ? 2'(PH_INEG) : 2'(PH_QNEG);
   endfunction
endpackage

// File: rtl/iq_qrate_phase.sv
module iq_qrate_phase
   import iq_qrate_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    step,
   output qphase_e phase
);
   qphase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= PH_IPOS;
      else if (step)
         phase_q <= qphase_e'(phase_q + 2'd1);
   end

   assign phase = phase_q;
endmodule

// File: rtl/iq_qrate_lane.sv
module iq_qrate_lane
   import iq_qrate_pkg::*;
#(
   parameter int         IN_W    = 12,
   parameter logic [1:0] POS_PH  = 2'd0,
   parameter logic [1:0] NEG_PH  = 2'd2,
   parameter bit         XOR_NEG = 1'b0,
   localparam int        OUT_W   = IN_W + 1
) (
   input  logic                    valid,
   input  qphase_e                 phase,
   input  logic signed [IN_W-1:0]  x,
   output logic                    take,
   output logic signed [OUT_W-1:0] y
);
   logic signed [OUT_W-1:0] x_ext;
   logic                    neg;

   if (POS_PH[0] != NEG_PH[0] || POS_PH == NEG_PH) begin : g_bad_phase
      $error("iq_qrate_lane: carrier phases must share parity and differ");
   end

   assign x_ext = {x[IN_W-1], x};
   assign neg   = (phase == qphase_e'(NEG_PH));
   assign take  = valid && (phase == qphase_e'(POS_PH) || neg);

   if (XOR_NEG) begin : g_xor_neg
      assign y = (x_ext ^ {OUT_W{neg}}) + OUT_W'(neg);
   end else begin : g_arith_neg
      assign y = neg ? -x_ext : x_ext;
   end
endmodule

// File: rtl/iq_qrate_pair.sv
module iq_qrate_pair #(
   parameter int  IN_W  = 12,
   localparam int OUT_W = IN_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    i_take,
   input  logic signed [OUT_W-1:0] i_y,
   input  logic                    q_take,
   input  logic signed [OUT_W-1:0] q_y,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);
   logic signed [OUT_W-1:0] i_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         i_hold <= '0;
      else if (i_take)
         i_hold <= i_y;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= q_take;
         if (q_take) begin
            out_i <= i_hold;
            out_q <= q_y;
         end
      end
   end
endmodule

// File: rtl/iq_qrate_ddc.sv
module iq_qrate_ddc
   import iq_qrate_pkg::*;
#(
   parameter int  IN_W    = 12,
   parameter bit  XOR_NEG = 1'b0,
   localparam int OUT_W   = IN_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_x,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);
   if (IN_W < 2) begin : g_bad_width
      $error("iq_qrate_ddc: IN_W must be at least 2");
   end

   qphase_e                 ph;
   logic [NUM_LANES-1:0]    take;
   logic signed [OUT_W-1:0] lane_y [NUM_LANES];

   iq_qrate_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (in_valid),
      .phase (ph)
   );

   for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      iq_qrate_lane #(
         .IN_W    (IN_W),
         .POS_PH  (lane_pos_phase(ln)),
         .NEG_PH  (lane_neg_phase(ln)),
         .XOR_NEG (XOR_NEG)
      ) u_lane (
         .valid (in_valid),
         .phase (ph),
         .x     (in_x),
         .take  (take[ln]),
         .y     (lane_y[ln])
      );
   end

   iq_qrate_pair #(.IN_W(IN_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .i_take    (take[LANE_I]),
      .i_y       (lane_y[LANE_I]),
      .q_take    (take[LANE_Q]),
      .q_y       (lane_y[LANE_Q]),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );
endmodule

// File: rtl/iq_qrate_ddc_chk.sv
module iq_qrate_ddc_chk #(
   parameter int  IN_W  = 12,
   localparam int OUT_W = IN_W + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic signed [IN_W-1:0]  in_x,
   input logic [1:0]              phase,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_i,
   input logic signed [OUT_W-1:0] out_q
);
   logic signed [OUT_W-1:0] x_ext;
   assign x_ext = {in_x[IN_W-1], in_x};

   // R4: a pair strobe follows every accepted odd-phase sample
   p_strobe_after_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase[0]) |=> out_valid);

   // R4: no strobe without an accepted odd-phase sample
   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && phase[0]) |=> !out_valid);

   // R5: idle cycles leave the phase alone
   p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(phase));

   // R5: accepted samples move the phase by one
   p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (phase == $past(phase) + 2'd1));

   // R3: phase-1 sample appears negated on Q
   p_q_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == 2'd1) |=> (out_q == -$past(x_ext)));

   // R3: phase-3 sample appears unchanged on Q
   p_q_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == 2'd3) |=> (out_q == $past(x_ext)));

   // R6: most negative input at phase 1 comes out positive
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == 2'd1 && in_x == {1'b1, {(IN_W-1){1'b0}}})
      |=> (out_q > 0));

   // R7: data holds between strobes
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind iq_qrate_ddc iq_qrate_ddc_chk #(.IN_W(IN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .phase     (ph),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q)
);

// File: tb/iq_qrate_ddc_bench.sv
`timescale 1ns/1ps
module iq_qrate_ddc_bench;
   localparam int IN_W  = 4;
   localparam int OUT_W = IN_W + 1;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic signed [IN_W-1:0]  in_x = '0;
   logic                    out_valid;
   logic signed [OUT_W-1:0] out_i;
   logic signed [OUT_W-1:0] out_q;

   int  errors = 0;
   int  checks = 0;
   bit  done = 0;

   // bench model state
   int  n_acc = 0;     // accepted samples since reset
   int  m_ihold = 0;   // pending I value of current pair
   int  exp_i = 0;
   int  exp_q = 0;
   bit  exp_v = 0;

   always #2 clk = ~clk;

   iq_qrate_ddc #(.IN_W(IN_W)) u_iq_qrate_ddc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: check result of the previous drive, then drive the next input
   task automatic step(input bit v, input int x);
      @(negedge clk);
      check("R4 out_valid", int'(out_valid), int'(exp_v));
      if (exp_v) begin
         check("R2/R8 out_i", int'(out_i), exp_i);
         check("R3/R6 out_q", int'(out_q), exp_q);
      end else begin
         check("R7 out_i hold", int'(out_i), exp_i);
         check("R7 out_q hold", int'(out_q), exp_q);
      end
      exp_v = 0;
      if (v) begin
         case (n_acc % 4)
            0: m_ihold = x;
            1: begin exp_v = 1; exp_i = m_ihold; exp_q = -x; end
            2: m_ihold = -x;
            default: begin exp_v = 1; exp_i = m_ihold; exp_q = x; end
         endcase
         n_acc++;
      end
      in_valid = v;
      in_x     = IN_W'(x);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_valid in reset", int'(out_valid), 0);
      check("R1 out_i in reset", int'(out_i), 0);
      check("R1 out_q in reset", int'(out_q), 0);
      rst_n = 1'b1;

      // R2 R3 R6 R8: every value at every phase; R5: gaps inside pairs
      for (int k = 0; k < 64; k++) begin
         int v;
         v = (((k >> 2) + (k & 3)) & 15);
         if (v > 7) v = v - 16;
         if (k % 3 == 1) step(1'b0, 5);
         if (k % 7 == 2) step(1'b0, -3);
         step(1'b1, v);
      end
      step(1'b0, 0);
      step(1'b0, 0);

      // R1: reset in the middle of a pair abandons it
      step(1'b1, 6);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check("R1 out_valid after mid reset", int'(out_valid), 0);
      check("R1 out_i after mid reset", int'(out_i), 0);
      check("R1 out_q after mid reset", int'(out_q), 0);
      rst_n = 1'b1;
      n_acc = 0; m_ihold = 0; exp_i = 0; exp_q = 0; exp_v = 0;
      step(1'b1, -8);    // phase 0 again: I = -8
      step(1'b1, -8);    // phase 1: Q = +8 (R6)
      step(1'b1, 7);
      step(1'b1, -8);    // phase 3: Q = -8
      step(1'b0, 0);
      step(1'b0, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule